// File: doc/BRIEF.md
# Address-Region Wait-State Timer

This block charges bus access time to a running master-clock counter. Each cycle it may see one CPU access on a 24-bit address. It sorts the address into one of four speed classes using bit tests and small offset sums on the address. No lookup table is involved. It then turns the class into a cycle cost and adds that cost to the counter. A 16-bit access to plain memory costs two byte times, charged in a single step. While a DMA transfer owns the bus, the CPU pays nothing, so no cost is charged.

The counter is compared every cycle against a next-event threshold supplied from outside. When the counter is at or above the threshold, the block raises a one-cycle service request. The event handler can move the threshold on while the request is low. If the handler leaves the threshold where it was, the request keeps coming back on every second cycle until the condition clears.

Top module: `wait_state_timer`

## Requirements
- R1: When address bit 22 or bit 15 is set, the class is fast (code 0) if bit 23 is set, and slow (code 2) if bit 23 is clear.
- R2: When R1 does not apply and the in-bank offset (bits 15..0) is below 0x2000 or at 0x6000 or above, the class is slow (code 2).
- R3: When R1 and R2 do not apply, offsets 0x4000 to 0x41FF give extra-slow (code 3), and every other offset gives normal (code 1).
- R4: A charged byte access costs NORM_CLK, SLOW_CLK or XSLOW_CLK for the normal, slow and extra-slow classes. The fast class costs FAST_CLK when fast_rom_en is 1 and SLOW_CLK when it is 0.
- R5: A charged access with acc_word high costs exactly twice the byte cost, and it is applied in one cycle.
- R6: While dma_busy is high, cyc_incr is 0 and cycle_count does not change.
- R7: While acc_valid is low, cyc_incr is 0 and cycle_count does not change.
- R8: At each clock edge out of reset, cycle_count takes its previous value plus the cyc_incr presented before that edge, modulo 2^CNT_W.
- R9: event_req goes high for one cycle after any cycle in which cycle_count >= next_event and event_req was low. It is never high on two cycles in a row.
- R10: A synchronous active-low reset clears cycle_count and event_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access occurs this cycle |
| acc_addr | input | 24 | Access address (bank in bits 23..16) |
| acc_word | input | 1 | Access is 16 bits wide |
| dma_busy | input | 1 | DMA owns the bus; suppress charging |
| fast_rom_en | input | 1 | Selects the short cost for the fast class |
| next_event | input | CNT_W | Event threshold, sampled every cycle |
| speed_class | output | 2 | 0 fast, 1 normal, 2 slow, 3 extra-slow |
| cyc_incr | output | INC_W | Cost charged at the coming edge |
| cycle_count | output | CNT_W | Running master-clock count |
| event_req | output | 1 | One-cycle event service request |

## Verification
The bench builds the block with CNT_W = 10. This lets the counter wrap many times in a few hundred cycles and makes threshold crossings frequent. It also sets FAST_CLK = 5, so a wrong choice between the fast and normal costs shows up as a different increment instead of matching by chance. The other costs keep their defaults (6, 8, 12). A word access to extra-slow space therefore produces the widest increment, 24.

// File: rtl/wst_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the wait-state timer.
// Assumes a 24-bit address with the bank in the top byte.
package wst_pkg;
    localparam int ADDR_W = 24;

    typedef enum logic [1:0] {
        SPD_FAST  = 2'd0,
        SPD_NORM  = 2'd1,
        SPD_SLOW  = 2'd2,
        SPD_XSLOW = 2'd3
    } spd_class_e;
endpackage

// File: rtl/wst_region_decode.sv
`timescale 1ns/1ps
// Region decoder: sorts an address into a speed class.
// It uses bit tests and two 16-bit offset sums, with no table.
// It is purely combinational. clk and rst_n serve only the local checks.
module wst_region_decode
    import wst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output spd_class_e        cls
);
    logic [15:0] ofs;
    logic [15:0] ofs_up;
    logic [15:0] ofs_dn;
    logic        unused_bits;

    assign ofs    = addr[15:0];
    assign ofs_up = ofs + 16'h6000;
    assign ofs_dn = ofs - 16'h4000;
    assign unused_bits = ^{addr[21:16], ofs_up[15], ofs_up[13:0], ofs_dn[15], ofs_dn[8:0]};

    // Priority chain: ROM-side test, then the low/high slow window, then the I/O window.
    always_comb begin
        if (addr[22] || addr[15])
            cls = addr[23] ? SPD_FAST : SPD_SLOW;
        else if (ofs_up[14])
            cls = SPD_SLOW;
        else if (|ofs_dn[14:9])
            cls = SPD_NORM;
        else
            cls = SPD_XSLOW;
    end

    assert_fast_region_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[23] && addr[15]) |-> cls == SPD_FAST);
    assert_low_page_slow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr[22] && addr[15:13] == 3'b000) |-> cls == SPD_SLOW);
    assert_xslow_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cls == SPD_XSLOW |-> (!addr[22] && addr[15:9] == 7'b0100000));
endmodule

// File: rtl/wst_charge_calc.sv
`timescale 1ns/1ps
// Charge calculator: turns a speed class into the clocks charged this cycle.
// Word accesses double the byte cost. Idle or DMA cycles charge nothing.
// It assumes INC_W can hold twice the largest cost.
module wst_charge_calc
    import wst_pkg::*;
#(
    parameter int FAST_CLK  = 6,
    parameter int NORM_CLK  = 6,
    parameter int SLOW_CLK  = 8,
    parameter int XSLOW_CLK = 12,
    parameter int INC_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  spd_class_e       cls,
    input  logic             valid,
    input  logic             word,
    input  logic             dma,
    input  logic             fast_en,
    output logic [INC_W-1:0] incr
);
    logic [INC_W-1:0] per_byte;

    // Per-byte cost of the class. The fast class falls back to slow when disabled.
    always_comb begin
        unique case (cls)
            SPD_FAST:  per_byte = fast_en ? INC_W'(FAST_CLK) : INC_W'(SLOW_CLK);
            SPD_NORM:  per_byte = INC_W'(NORM_CLK);
            SPD_SLOW:  per_byte = INC_W'(SLOW_CLK);
            default:   per_byte = INC_W'(XSLOW_CLK);
        endcase
    end

    // Final increment: gated by access and DMA, doubled for a word.
    always_comb begin
        if (!valid || dma)
            incr = '0;
        else if (word)
            incr = per_byte << 1;
        else
            incr = per_byte;
    end

    assert_fast_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == SPD_FAST && !fast_en && valid && !dma && !word) |-> incr == INC_W'(SLOW_CLK));
    assert_word_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && word && !dma) |-> (incr[0] == 1'b0 && incr != '0));
    assert_dma_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dma |-> incr == '0);
    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> incr == '0);
endmodule

// File: rtl/wst_cycle_accum.sv
`timescale 1ns/1ps
// Cycle accumulator: adds each increment to the count and raises the event pulse.
// The count wraps modulo 2^CNT_W. The threshold is compared against the
// registered count every cycle, and a pulse is always followed by one low cycle.
module wst_cycle_accum #(
    parameter int CNT_W = 32,
    parameter int INC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] incr,
    input  logic [CNT_W-1:0] next_event,
    output logic [CNT_W-1:0] count,
    output logic             event_req
);
    logic [CNT_W-1:0] count_q;
    logic             evt_q;

    // Count and event registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            evt_q   <= 1'b0;
        end else begin
            count_q <= count_q + CNT_W'(incr);
            evt_q   <= (count_q >= next_event) && !evt_q;
        end
    end

    assign count     = count_q;
    assign event_req = evt_q;

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> count_q == CNT_W'($past(count_q) + CNT_W'($past(incr))));
    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |=> !evt_q);
    assert_rise_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_q) |-> $past(count_q >= next_event));
    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (count_q == '0 && !evt_q));
endmodule

// File: rtl/wait_state_timer.sv
`timescale 1ns/1ps
// Wait-state timer top: region decode, then charge, then accumulate.
// It assumes one access at most per cycle. The output speed_class and
// cyc_incr are combinational in the current inputs.
module wait_state_timer
    import wst_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int FAST_CLK  = 6,
    parameter int NORM_CLK  = 6,
    parameter int SLOW_CLK  = 8,
    parameter int XSLOW_CLK = 12,
    localparam int MAX_A    = (FAST_CLK > NORM_CLK) ? FAST_CLK : NORM_CLK,
    localparam int MAX_B    = (SLOW_CLK > XSLOW_CLK) ? SLOW_CLK : XSLOW_CLK,
    localparam int MAX_CLK  = (MAX_A > MAX_B) ? MAX_A : MAX_B,
    localparam int INC_W    = $clog2(2 * MAX_CLK + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [23:0]       acc_addr,
    input  logic              acc_word,
    input  logic              dma_busy,
    input  logic              fast_rom_en,
    input  logic [CNT_W-1:0]  next_event,
    output logic [1:0]        speed_class,
    output logic [INC_W-1:0]  cyc_incr,
    output logic [CNT_W-1:0]  cycle_count,
    output logic              event_req
);
    spd_class_e cls;

    wst_region_decode u_decode (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (acc_addr),
        .cls  (cls)
    );

    wst_charge_calc #(
        .FAST_CLK (FAST_CLK),
        .NORM_CLK (NORM_CLK),
        .SLOW_CLK (SLOW_CLK),
        .XSLOW_CLK(XSLOW_CLK),
        .INC_W    (INC_W)
    ) u_charge (
        .clk    (clk),
        .rst_n  (rst_n),
        .cls    (cls),
        .valid  (acc_valid),
        .word   (acc_word),
        .dma    (dma_busy),
        .fast_en(fast_rom_en),
        .incr   (cyc_incr)
    );

    wst_cycle_accum #(
        .CNT_W(CNT_W),
        .INC_W(INC_W)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .incr      (cyc_incr),
        .next_event(next_event),
        .count     (cycle_count),
        .event_req (event_req)
    );

    assign speed_class = cls;

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid || dma_busy) |=> $stable(cycle_count));
endmodule

// File: tb/wait_state_timer_tb_top.sv
`timescale 1ns/1ps
module wait_state_timer_tb_top;
    localparam int CNT_W = 10;
    localparam int FCLK = 5, NCLK = 6, SCLK = 8, XCLK = 12;
    localparam int INC_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0, acc_word = 1'b0, dma_busy = 1'b0, fast_rom_en = 1'b0;
    logic [23:0] acc_addr = '0;
    logic [CNT_W-1:0] next_event = '1;
    logic [1:0] speed_class;
    logic [INC_W-1:0] cyc_incr;
    logic [CNT_W-1:0] cycle_count;
    logic event_req;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [CNT_W-1:0] m_cnt = '0;
    logic m_evt = 1'b0;

    always #2.5 clk = ~clk;

    wait_state_timer #(
        .CNT_W(CNT_W), .FAST_CLK(FCLK), .NORM_CLK(NCLK), .SLOW_CLK(SCLK), .XSLOW_CLK(XCLK)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_word(acc_word), .dma_busy(dma_busy), .fast_rom_en(fast_rom_en),
        .next_event(next_event), .speed_class(speed_class), .cyc_incr(cyc_incr),
        .cycle_count(cycle_count), .event_req(event_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected class from address ranges: 0 fast, 1 normal, 2 slow, 3 extra-slow.
    function automatic logic [1:0] model_class(input logic [23:0] a);
        logic [15:0] o = a[15:0];
        if (a[22] || a[15]) return a[23] ? 2'd0 : 2'd2;
        if (o < 16'h2000 || o >= 16'h6000) return 2'd2;
        if (o >= 16'h4000 && o < 16'h4200) return 2'd3;
        return 2'd1;
    endfunction

    function automatic string class_req(input logic [23:0] a);
        if (a[22] || a[15]) return "R1";
        if (a[15:0] < 16'h2000 || a[15:0] >= 16'h6000) return "R2";
        return "R3";
    endfunction

    function automatic int model_incr(input logic [1:0] c, input logic v, w, d, f);
        int b;
        if (!v || d) return 0;
        case (c)
            2'd0: b = f ? FCLK : SCLK;
            2'd1: b = NCLK;
            2'd2: b = SCLK;
            default: b = XCLK;
        endcase
        return w ? 2 * b : b;
    endfunction

    task automatic run(input logic [23:0] a, input logic v, w, d, f, input logic [CNT_W-1:0] ne);
        logic [1:0] ec;
        int ei;
        logic nevt;
        string ireq;
        @(negedge clk);
        acc_addr = a; acc_valid = v; acc_word = w; dma_busy = d; fast_rom_en = f; next_event = ne;
        #0.5;
        ec = model_class(a);
        ei = model_incr(ec, v, w, d, f);
        ireq = !v ? "R7" : (d ? "R6" : (w ? "R5" : "R4"));
        chk(class_req(a), 32'(speed_class), 32'(ec));
        chk(ireq, 32'(cyc_incr), 32'(ei));
        nevt  = (m_cnt >= ne) && !m_evt;
        m_cnt = m_cnt + CNT_W'(ei);
        m_evt = nevt;
        @(posedge clk);
        #0.5;
        chk("R8", 32'(cycle_count), 32'(m_cnt));
        chk("R9", 32'(event_req), 32'(m_evt));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [CNT_W-1:0] ne;
        void'($urandom(32'h5EED_0417));
        // R10: reset with a costly access applied
        acc_valid = 1'b1; acc_addr = 24'h004000; acc_word = 1'b1; next_event = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", 32'(cycle_count), 32'd0);
        chk("R10", 32'(event_req), 32'd0);
        acc_valid = 1'b0; next_event = '1;
        rst_n = 1'b1;

        // Directed corners of the region map
        run(24'h000000, 1, 0, 0, 0, '1);   // R2 low page
        run(24'h001FFF, 1, 0, 0, 0, '1);   // R2
        run(24'h002000, 1, 0, 0, 0, '1);   // R3 normal
        run(24'h003FFF, 1, 0, 0, 0, '1);   // R3 normal
        run(24'h004000, 1, 0, 0, 0, '1);   // R3 extra-slow
        run(24'h0041FF, 1, 0, 0, 0, '1);   // R3 extra-slow edge
        run(24'h004200, 1, 0, 0, 0, '1);   // R3 normal after window
        run(24'h005FFF, 1, 0, 0, 0, '1);   // R3
        run(24'h006000, 1, 0, 0, 0, '1);   // R2 high slow
        run(24'h008000, 1, 0, 0, 0, '1);   // R1 slow bank
        run(24'h400000, 1, 0, 0, 1, '1);   // R1 bit22, no bit23
        run(24'h808000, 1, 0, 0, 0, '1);   // R1 fast region, R4 disabled
        run(24'h808000, 1, 0, 0, 1, '1);   // R1, R4 fast enabled
        run(24'hC00000, 1, 1, 0, 1, '1);   // R5 word fast
        run(24'h004100, 1, 1, 0, 0, '1);   // R5 word extra-slow (24)
        run(24'h801000, 1, 0, 0, 1, '1);   // R2 bank 0x80 low page
        run(24'h004000, 1, 1, 1, 0, '1);   // R6 DMA
        run(24'h004000, 0, 1, 0, 0, '1);   // R7 idle
        // R9: threshold held low while idle gives alternating pulses
        for (int i = 0; i < 6; i++) run(24'h0, 0, 0, 0, 0, '0);
        // R9: handler raises threshold after a pulse
        run(24'h0, 0, 0, 0, 0, m_cnt + 10'd3);
        for (int i = 0; i < 4; i++) run(24'h002000, 1, 0, 0, 0, m_cnt + 10'd3);

        // Constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [23:0] a;
            a = 24'($urandom);
            if (($urandom % 3) == 0) a[23:16] = 8'h00;
            if (($urandom % 4) == 0) a[15:9] = 7'b0100000;
            ne = (($urandom % 4) == 0) ? (m_cnt - CNT_W'($urandom % 8)) : CNT_W'($urandom);
            run(a, ($urandom % 8) != 0, $urandom % 2, ($urandom % 6) == 0, $urandom % 2, ne);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule